// File: doc/BRIEF.md
# Single-Wire Slave Slot Timing Front End

This block is the bit-level edge of a slave on a single-wire open-drain bus. It watches the synchronized line level and times every low period in microseconds. The microsecond tick is derived inside the block from a clock-frequency parameter. Each low period is classified as one of three things: a bus reset, a master write slot, or the start of a read slot. After a reset the block answers with a presence pulse. In a write slot it samples the line at a fixed point and hands one received bit upward. In a read slot it takes one transmit bit from the layer above and pulls the line low for a zero.

The block has two timing sets, regular and overdrive. The command layer requests overdrive, and overdrive then stays in force until a long reset returns the block to regular speed. While in overdrive, a much shorter low also counts as a reset, and that short reset keeps the fast mode. The layer above selects the slot direction with a mode input. Byte assembly and command decoding are handled outside this block.

Top module: `ow_slot_frontend`

## Requirements
- R1: When the line rises after a low of at least 480 µs, reset_seen_o pulses for one cycle and od_o clears in the same cycle. At regular speed, a low of 60 to 479 µs is not a reset.
- R2: With od_o high, a low of 48 to 479 µs ends as a reset: reset_seen_o pulses and od_o stays high.
- R3: After a reset the block waits 30 µs (3 µs in overdrive) and then pulls the line for 120 µs (12 µs). Both fall inside the 15–60/60–240 µs window (2–6/8–24 µs in overdrive).
- R4: With tx_mode_i low, a falling edge starts a write slot. 30 µs (3 µs in overdrive) later, bit_valid_o pulses for one cycle and bit_value_o carries the line level at that moment, so a 1–15 µs low gives 1 and a 60 µs or longer low gives 0.
- R5: With tx_mode_i high, a falling edge makes tx_request_o pulse for one cycle and captures tx_bit_i. A captured 0 pulls the line for 30 µs (3 µs in overdrive). A captured 1 leaves the line released.
- R6: A one-cycle od_req_i sets od_o on the next cycle, and od_o stays set for all following slots until a reset of 480 µs or longer.
- R7: A falling edge during the presence wait or presence pulse produces no received bit and no transmit request. A new slot is accepted only after the line has been seen high.
- R8: A low that exceeds the reset minimum ends as a reset even when it began as a read slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Synchronized bus level |
| tx_mode_i | input | 1 | 1: next slots are read slots (slave transmits) |
| tx_bit_i | input | 1 | Bit to send in the next read slot |
| od_req_i | input | 1 | Pulse that switches to overdrive timing |
| reset_seen_o | output | 1 | One-cycle pulse on a detected reset |
| bit_valid_o | output | 1 | One-cycle pulse, received bit ready |
| bit_value_o | output | 1 | Received bit |
| tx_request_o | output | 1 | One-cycle pulse, tx_bit_i consumed |
| pull_o | output | 1 | Open-drain pull-down enable |
| od_o | output | 1 | Overdrive timing active |

## Verification
The bench targets the reset thresholds in both speeds. A 60 µs low must be a reset only in overdrive. A design that mixed up the two thresholds would either drop out of overdrive on a short reset or answer a long write-0 with a presence pulse. The bench also times the presence wait and pulse width from the pins, runs read and write slots at both speeds, and checks the line level inside the read-0 hold window. One test glitches the line during the presence wait: a design that did not mask that edge would report a phantom bit. Another holds a read-0 slot low for 500 µs: a design that stayed in the slot would miss that reset.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSLOT,
    ST_RSLOT,
    ST_WAIT_HIGH,
    ST_PD_WAIT,
    ST_PD_DRIVE
  } slot_state_e;

  function automatic int unsigned pick_us(input logic od, input int unsigned reg_us,
                                          input int unsigned od_us);
    return od ? od_us : reg_us;
  endfunction
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DW = $clog2(DIV + 1);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == DW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ow_edge_timer.sv
module ow_edge_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic          tick_i,
  output logic          fall_o,
  output logic          rise_o,
  output logic [CW-1:0] low_us_o
);
  logic line_q;

  assign fall_o = line_q & ~line_i;
  assign rise_o = ~line_q & line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= 1'b1;
      low_us_o <= '0;
    end else begin
      line_q <= line_i;
      if (fall_o) low_us_o <= '0;
      else if (!line_i && tick_i && (low_us_o != '1)) low_us_o <= low_us_o + 1'b1;
    end
  end
endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_pkg::*;
#(
  parameter int unsigned CW            = 10,
  parameter int unsigned RST_MIN_US    = 480,
  parameter int unsigned OD_RST_MIN_US = 48,
  parameter int unsigned PD_WAIT_US    = 30,
  parameter int unsigned OD_PD_WAIT_US = 3,
  parameter int unsigned PD_LEN_US     = 120,
  parameter int unsigned OD_PD_LEN_US  = 12,
  parameter int unsigned SAMPLE_US     = 30,
  parameter int unsigned OD_SAMPLE_US  = 3,
  parameter int unsigned HOLD_US       = 30,
  parameter int unsigned OD_HOLD_US    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic          fall_i,
  input  logic          rise_i,
  input  logic [CW-1:0] low_us_i,
  input  logic          tx_mode_i,
  input  logic          tx_bit_i,
  input  logic          od_req_i,
  output logic          reset_seen_o,
  output logic          bit_valid_o,
  output logic          bit_value_o,
  output logic          tx_request_o,
  output logic          pull_o,
  output logic          od_o
);
  slot_state_e   st_q;
  logic [CW-1:0] el_q;
  logic          self_low_q;
  logic          long_rst, short_rst;
  logic [CW-1:0] t_sample, t_hold, t_pdw, t_pdl;

  assign t_sample = CW'(pick_us(od_o, SAMPLE_US, OD_SAMPLE_US));
  assign t_hold   = CW'(pick_us(od_o, HOLD_US, OD_HOLD_US));
  assign t_pdw    = CW'(pick_us(od_o, PD_WAIT_US, OD_PD_WAIT_US));
  assign t_pdl    = CW'(pick_us(od_o, PD_LEN_US, OD_PD_LEN_US));

  // a low started by our own pull-down never counts as a reset
  assign long_rst  = rise_i && !self_low_q && (low_us_i >= CW'(RST_MIN_US));
  assign short_rst = rise_i && !self_low_q && od_o && (low_us_i >= CW'(OD_RST_MIN_US));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      el_q         <= '0;
      self_low_q   <= 1'b0;
      reset_seen_o <= 1'b0;
      bit_valid_o  <= 1'b0;
      bit_value_o  <= 1'b0;
      tx_request_o <= 1'b0;
      pull_o       <= 1'b0;
      od_o         <= 1'b0;
    end else begin
      reset_seen_o <= 1'b0;
      bit_valid_o  <= 1'b0;
      tx_request_o <= 1'b0;
      if (tick_i && (el_q != '1)) el_q <= el_q + 1'b1;
      if (fall_i) self_low_q <= pull_o;
      if (od_req_i) od_o <= 1'b1;

      if (long_rst || short_rst) begin
        reset_seen_o <= 1'b1;
        pull_o       <= 1'b0;
        st_q         <= ST_PD_WAIT;
        el_q         <= '0;
        if (long_rst) od_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (fall_i) begin
            el_q <= '0;
            if (tx_mode_i) begin
              tx_request_o <= 1'b1;
              pull_o       <= ~tx_bit_i;
              st_q         <= ST_RSLOT;
            end else begin
              st_q <= ST_WSLOT;
            end
          end
          ST_WSLOT: if (el_q >= t_sample) begin
            bit_valid_o <= 1'b1;
            bit_value_o <= line_i;
            st_q        <= ST_WAIT_HIGH;
          end
          ST_RSLOT: if (el_q >= t_hold) begin
            pull_o <= 1'b0;
            st_q   <= ST_WAIT_HIGH;
          end
          ST_WAIT_HIGH: if (line_i && !pull_o) st_q <= ST_IDLE;
          ST_PD_WAIT: if (el_q >= t_pdw) begin
            pull_o <= 1'b1;
            el_q   <= '0;
            st_q   <= ST_PD_DRIVE;
          end
          ST_PD_DRIVE: if (el_q >= t_pdl) begin
            pull_o <= 1'b0;
            st_q   <= ST_WAIT_HIGH;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ow_slot_frontend.sv
module ow_slot_frontend #(
  parameter int unsigned CLK_FREQ_HZ   = 50_000_000,
  parameter int unsigned RST_MIN_US    = 480,
  parameter int unsigned OD_RST_MIN_US = 48,
  parameter int unsigned PD_WAIT_US    = 30,
  parameter int unsigned OD_PD_WAIT_US = 3,
  parameter int unsigned PD_LEN_US     = 120,
  parameter int unsigned OD_PD_LEN_US  = 12,
  parameter int unsigned SAMPLE_US     = 30,
  parameter int unsigned OD_SAMPLE_US  = 3,
  parameter int unsigned HOLD_US       = 30,
  parameter int unsigned OD_HOLD_US    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic tx_mode_i,
  input  logic tx_bit_i,
  input  logic od_req_i,
  output logic reset_seen_o,
  output logic bit_valid_o,
  output logic bit_value_o,
  output logic tx_request_o,
  output logic pull_o,
  output logic od_o
);
  localparam int unsigned TICK_DIV = CLK_FREQ_HZ / 1_000_000;
  localparam int unsigned CW       = $clog2(RST_MIN_US + 1) + 1;

  logic          tick;
  logic          fall, rise;
  logic [CW-1:0] low_us;

  ow_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ow_edge_timer #(.CW(CW)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .tick_i  (tick),
    .fall_o  (fall),
    .rise_o  (rise),
    .low_us_o(low_us)
  );

  ow_slot_ctrl #(
    .CW(CW), .RST_MIN_US(RST_MIN_US), .OD_RST_MIN_US(OD_RST_MIN_US),
    .PD_WAIT_US(PD_WAIT_US), .OD_PD_WAIT_US(OD_PD_WAIT_US),
    .PD_LEN_US(PD_LEN_US), .OD_PD_LEN_US(OD_PD_LEN_US),
    .SAMPLE_US(SAMPLE_US), .OD_SAMPLE_US(OD_SAMPLE_US),
    .HOLD_US(HOLD_US), .OD_HOLD_US(OD_HOLD_US)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .line_i      (line_i),
    .fall_i      (fall),
    .rise_i      (rise),
    .low_us_i    (low_us),
    .tx_mode_i   (tx_mode_i),
    .tx_bit_i    (tx_bit_i),
    .od_req_i    (od_req_i),
    .reset_seen_o(reset_seen_o),
    .bit_valid_o (bit_valid_o),
    .bit_value_o (bit_value_o),
    .tx_request_o(tx_request_o),
    .pull_o      (pull_o),
    .od_o        (od_o)
  );
endmodule

// File: rtl/ow_slot_frontend_chk.sv
module ow_slot_frontend_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_bit_i,
  input logic od_req_i,
  input logic reset_seen_o,
  input logic bit_valid_o,
  input logic tx_request_o,
  input logic pull_o,
  input logic od_o
);
  a_r5_read_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_request_o |-> (pull_o != $past(tx_bit_i)));

  a_r5_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_request_o |=> !tx_request_o);

  a_r6_od_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(od_o) |-> $past(od_req_i));

  a_r1_od_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(od_o) |-> reset_seen_o);

  a_r3_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_seen_o |-> !pull_o);

  a_r4_sample_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (!pull_o && !reset_seen_o));
endmodule

bind ow_slot_frontend ow_slot_frontend_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_bit_i    (tx_bit_i),
  .od_req_i    (od_req_i),
  .reset_seen_o(reset_seen_o),
  .bit_valid_o (bit_valid_o),
  .tx_request_o(tx_request_o),
  .pull_o      (pull_o),
  .od_o        (od_o)
);

// File: tb/tb_ow_slot_frontend.sv
module tb_ow_slot_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;  // clocks per microsecond

  // vector: {is_read, bit}
  localparam logic [1:0] VEC [0:7] = '{2'b00, 2'b01, 2'b11, 2'b10,
                                       2'b01, 2'b10, 2'b00, 2'b11};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_line = 1'b1;
  logic tx_mode = 1'b0, tx_bit = 1'b1, od_req = 1'b0;
  logic reset_seen, bit_valid, bit_value, tx_request, pull, od;
  logic bus;

  int checks = 0, fails = 0;
  int n_rst = 0, n_bits = 0, n_txr = 0;
  logic last_bit = 1'b0;
  longint cyc = 0, t_rs = 0, t_pr = 0, t_pf = 0;
  logic pull_prev = 1'b0;

  assign bus = m_line & ~pull;
  always #(CLK_PERIOD / 2) clk = ~clk;

  ow_slot_frontend #(.CLK_FREQ_HZ(CPU * 1_000_000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(bus), .tx_mode_i(tx_mode),
    .tx_bit_i(tx_bit), .od_req_i(od_req), .reset_seen_o(reset_seen),
    .bit_valid_o(bit_valid), .bit_value_o(bit_value), .tx_request_o(tx_request),
    .pull_o(pull), .od_o(od)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    pull_prev <= pull;
    if (reset_seen) begin n_rst <= n_rst + 1; t_rs <= cyc; end
    if (bit_valid) begin n_bits <= n_bits + 1; last_bit <= bit_value; end
    if (tx_request) n_txr <= n_txr + 1;
    if (pull && !pull_prev) t_pr <= cyc;
    if (!pull && pull_prev) t_pf <= cyc;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int us);
    repeat (us * CPU) @(negedge clk);
  endtask

  task automatic bus_reset(input int low_us, input bit fast);
    m_line = 1'b0;
    wait_us(low_us);
    m_line = 1'b1;
    wait_us(fast ? 40 : 300);
  endtask

  task automatic check_presence(input bit fast, input string tag);
    longint d = (t_pr - t_rs);
    longint w = (t_pf - t_pr);
    if (fast) begin
      chk(d >= 2 * CPU && d <= 6 * CPU, {tag, " presence delay"}, d, 3 * CPU);
      chk(w >= 8 * CPU && w <= 24 * CPU, {tag, " presence width"}, w, 12 * CPU);
    end else begin
      chk(d >= 15 * CPU && d <= 60 * CPU, {tag, " presence delay"}, d, 30 * CPU);
      chk(w >= 60 * CPU && w <= 240 * CPU, {tag, " presence width"}, w, 120 * CPU);
    end
  endtask

  task automatic write_slot(input bit b, input bit fast, input int low_us);
    int nb = n_bits;
    m_line = 1'b0;
    wait_us(low_us);
    m_line = 1'b1;
    wait_us(fast ? 16 - low_us : 100 - low_us);
    chk(n_bits == nb + 1, "R4 bit count", n_bits, nb + 1);
    chk(last_bit == b, "R4 bit value", last_bit, b);
  endtask

  task automatic read_slot(input bit b, input bit fast);
    int nt = n_txr;
    tx_mode = 1'b1;
    tx_bit  = b;
    m_line  = 1'b0;
    wait_us(1);
    m_line = 1'b1;
    if (fast) repeat (2) @(negedge clk);
    else wait_us(11);
    chk(bus == b, "R5 line level in read slot", bus, b);
    wait_us(fast ? 14 : 90);
    chk(n_txr == nt + 1, "R5 tx_request count", n_txr, nt + 1);
    tx_mode = 1'b0;
    tx_bit  = 1'b1;
  endtask

  initial begin
    int r0, b0;
    repeat (5) @(negedge clk);
    chk(pull == 1'b0, "R3 reset state pull", pull, 0);
    chk(od == 1'b0, "R6 reset state od", od, 0);
    chk(!reset_seen && !bit_valid && !tx_request, "R1 reset state pulses", 1, 0);
    rst_n = 1'b1;
    wait_us(3);

    // R1/R3 long reset at regular speed
    bus_reset(500, 1'b0);
    chk(n_rst == 1, "R1 long reset seen", n_rst, 1);
    check_presence(1'b0, "R3 regular");

    // table, regular speed (R4/R5)
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][1]) read_slot(VEC[i][0], 1'b0);
      else write_slot(VEC[i][0], 1'b0, VEC[i][0] ? 6 : 80);
    end

    // R4 boundaries: 15 us low gives 1, 60 us low gives 0; R1 not a reset
    write_slot(1'b1, 1'b0, 15);
    r0 = n_rst;
    write_slot(1'b0, 1'b0, 60);
    write_slot(1'b0, 1'b0, 200);
    chk(n_rst == r0, "R1 200us low at regular speed is no reset", n_rst, r0);

    // R7 glitch during presence wait
    b0 = n_bits;
    m_line = 1'b0; wait_us(500); m_line = 1'b1;
    wait_us(10);
    m_line = 1'b0; wait_us(3); m_line = 1'b1;
    wait_us(300);
    chk(n_bits == b0, "R7 no bit from presence glitch", n_bits, b0);
    check_presence(1'b0, "R7 presence kept");

    // R6 overdrive request
    @(negedge clk); od_req = 1'b1; @(negedge clk); od_req = 1'b0;
    @(negedge clk);
    chk(od == 1'b1, "R6 od set", od, 1);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][1]) read_slot(VEC[i][0], 1'b1);
      else write_slot(VEC[i][0], 1'b1, VEC[i][0] ? 1 : 8);
    end
    chk(od == 1'b1, "R6 od persists over slots", od, 1);

    // R2 short reset in overdrive
    r0 = n_rst;
    bus_reset(60, 1'b1);
    chk(n_rst == r0 + 1, "R2 short reset seen", n_rst, r0 + 1);
    chk(od == 1'b1, "R2 od kept", od, 1);
    check_presence(1'b1, "R3 overdrive");

    // R1 long reset clears overdrive
    r0 = n_rst;
    bus_reset(500, 1'b0);
    chk(n_rst == r0 + 1, "R1 long reset in od seen", n_rst, r0 + 1);
    chk(od == 1'b0, "R1 od cleared", od, 0);

    // R8 reset overrides a read-0 slot
    r0 = n_rst;
    tx_mode = 1'b1; tx_bit = 1'b0;
    bus_reset(500, 1'b0);
    tx_mode = 1'b0; tx_bit = 1'b1;
    chk(n_rst == r0 + 1, "R8 reset during read slot", n_rst, r0 + 1);
    chk(pull == 1'b0, "R8 line released after presence", pull, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule